// File: doc/BRIEF.md
# Framebuffer Raster Timing and Pixel Scanout

This block produces the raster timing for a display that reads a linear, chunky-packed framebuffer from a 128 KB video memory split into two 64 KB halves. A divider derives a dot enable from the system clock. Horizontal and vertical position counters advance on that enable, and the current counts are available on output ports so that a processor can read the beam position.

A 16-bit mode word controls the display. It sets the display enable, the pixel depth (4 or 8 bits), which 64 KB half is scanned, a palette group used in 4-bit mode, and two letterbox counts. The letterbox counts blank extra lines above and below the picture. A second register sets the byte offset of the picture's first pixel inside the scanned half.

For each dot the block issues a read address to the video memory. It takes the returned byte and turns it into an 8-bit index into a 256-entry colour table, together with a pixel-valid flag. The memory itself, the arbitration of the other half, and the colour table contents live outside this block.

Top module: `fbv_scanout`

## Requirements
- R1: `hcount` counts 0 to H_TOTAL-1 (default 415) and then returns to 0. It advances by one on each clock where `dot_tick` is high and holds on every other clock.
- R2: `vcount` counts 0 to V_TOTAL-1 (default 261) and then returns to 0. It advances only on a clock where `dot_tick` is high and `hcount` is H_TOTAL-1.
- R3: `dot_tick` is high on one clock in every DOT_DIV clocks. After reset is released, the first counter advance happens at the DOT_DIV-th rising edge. With DOT_DIV of 1 the counters advance on every edge.
- R4: While `rst` is high and after it falls, `hcount`, `vcount`, `vram_rd` and `pix_valid` are 0, and the mode word is 0 (display off).
- R5: The mode word fields are as follows. Bit 15 enables the display. Bit 14 selects the depth (0 = 4 bpp, 1 = 8 bpp). Bits 12:11 hold the palette group. Bits 10:6 hold the top blank count. Bits 5:1 hold the bottom blank count. Bit 0 selects the scanned half. Bit 13 has no effect on any output.
- R6: A dot is active when all of these hold: the display is enabled, `hcount` < ACTIVE_W (320), and `vcount` is at least the top blank count and below ACTIVE_H (240) minus the bottom blank count. `vram_rd` and `pix_valid` are high only for active dots.
- R7: For an active dot, `vram_addr[16]` equals mode bit 0. `vram_addr[15:0]` is (offset + row × bytes-per-line + column byte) mod 65536. Here row = `vcount` − top blank count. Bytes-per-line is 320 at 8 bpp and 160 at 4 bpp. The column byte is `hcount` at 8 bpp and `hcount`/2 at 4 bpp.
- R8: At 8 bpp, `pix_index` equals the fetched byte.
- R9: At 4 bpp, `pix_index` is {2'b00, palette group, nibble}. The nibble is bits 7:4 of the fetched byte for an even `hcount` and bits 3:0 for an odd one.
- R10: `vram_addr` and `vram_rd` are registered one clock after the counter state that produced them. `vram_rdata` is taken to arrive one clock after the address. `pix_valid` and `pix_index` appear three clocks after the counter state. `pix_index` is 0 whenever `pix_valid` is low.
- R11: A write strobe (`mode_we` or `base_we`) loads its register at that rising edge. The new value governs addresses from the following clock onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load strobe for the mode word |
| mode_wdata | input | 16 | Mode word value |
| base_we | input | 1 | Load strobe for the picture offset |
| base_wdata | input | 16 | Byte offset of the first pixel in the scanned half |
| vram_rdata | input | 8 | Byte returned by video memory one clock after the address |
| dot_tick | output | 1 | Dot enable, one clock in DOT_DIV |
| hcount | output | 9 | Horizontal position |
| vcount | output | 9 | Vertical position |
| vram_addr | output | 17 | Video memory byte address |
| vram_rd | output | 1 | Address belongs to an active dot |
| pix_valid | output | 1 | Pixel index is a visible pixel |
| pix_index | output | 8 | Colour table index |

## Verification
The bench targets the offset sum that crosses the 64 KB boundary inside the scanned half. A design that carried into bit 16 would read from the displayed-but-wrong half. It also probes the lines right at the top and bottom letterbox edges and the column edge at 319/320, where an off-by-one shows up as a missing or extra lit line or column. It checks nibble order in 4 bpp mode, where swapped halves produce mirrored pixel pairs, and the wrap of both counters, where a wrong terminal count shifts the whole frame. A spare mode bit is set during one stretch; any decoding of it changes the indices or addresses seen at the ports.

// File: rtl/fbv_pkg.sv
package fbv_pkg;

  // Mode word, MSB first; field positions are fixed by the programming model.
  typedef struct packed {
    logic       disp_on;
    logic       wide_pix;
    logic       spare;
    logic [1:0] pal_sel;
    logic [4:0] top_blank;
    logic [4:0] bot_blank;
    logic       front_hi;
  } fbv_mode_t;

  localparam int MODE_W = $bits(fbv_mode_t);

  // 4 bpp colour index: palette group in bits 5:4, pixel nibble below.
  function automatic logic [7:0] fbv_nibble_index(input logic [1:0] pal,
                                                  input logic [3:0] nib);
    return {2'b00, pal, nib};
  endfunction

endpackage

// File: rtl/fbv_dot_div.sv
module fbv_dot_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/fbv_raster.sv
module fbv_raster #(
  parameter int H_TOTAL = 416,
  parameter int V_TOTAL = 262,
  parameter int HW      = 9,
  parameter int VW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [HW-1:0] hc,
  output logic [VW-1:0] vc
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= '0;
      vc <= '0;
    end else if (tick) begin
      if (hc == H_LAST) begin
        hc <= '0;
        vc <= (vc == V_LAST) ? '0 : vc + 1'b1;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbv_fetch_addr.sv
module fbv_fetch_addr import fbv_pkg::*; #(
  parameter int ACTIVE_W = 320,
  parameter int ACTIVE_H = 240,
  parameter int HW       = 9,
  parameter int VW       = 9,
  parameter int BANK_AW  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HW-1:0]      hc,
  input  logic [VW-1:0]      vc,
  input  logic               disp_on,
  input  logic               wide_pix,
  input  logic [1:0]         pal_sel,
  input  logic [4:0]         top_blank,
  input  logic [4:0]         bot_blank,
  input  logic               front_hi,
  input  logic [BANK_AW-1:0] base,
  output logic [BANK_AW:0]   addr,
  output logic               rd,
  output logic               nib_hi,
  output logic               deep,
  output logic [1:0]         pal
);

  localparam int PW = BANK_AW + VW;
  localparam logic [HW-1:0] H_END = HW'(ACTIVE_W);

  logic [VW-1:0]      top_v, end_v, row;
  logic               in_h, in_v, act;
  logic [HW-1:0]      col;
  logic [BANK_AW-1:0] line_off, lin;

  always_comb begin
    top_v = VW'(top_blank);
    end_v = VW'(ACTIVE_H) - VW'(bot_blank);
    row   = vc - top_v;
    in_h  = (hc < H_END);
    in_v  = (vc >= top_v) && (vc < end_v);
    act   = disp_on && in_h && in_v;
    col   = wide_pix ? hc : (hc >> 1);
    if (wide_pix) line_off = BANK_AW'(PW'(row) * PW'(ACTIVE_W));
    else          line_off = BANK_AW'(PW'(row) * PW'(ACTIVE_W / 2));
    lin   = base + line_off + BANK_AW'(col);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      rd     <= 1'b0;
      nib_hi <= 1'b0;
      deep   <= 1'b0;
      pal    <= '0;
    end else begin
      addr   <= {front_hi, lin};
      rd     <= act;
      nib_hi <= ~hc[0];
      deep   <= wide_pix;
      pal    <= pal_sel;
    end
  end

endmodule

// File: rtl/fbv_pixel_form.sv
module fbv_pixel_form import fbv_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd1,
  input  logic       nib_hi1,
  input  logic       deep1,
  input  logic [1:0] pal1,
  input  logic [7:0] rdata,
  output logic       pix_valid,
  output logic [7:0] pix_index
);

  // Side information travels alongside the memory read latency.
  logic       act2, nib2, deep2;
  logic [1:0] pal2;
  logic [3:0] nib_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      act2  <= 1'b0;
      nib2  <= 1'b0;
      deep2 <= 1'b0;
      pal2  <= '0;
    end else begin
      act2  <= rd1;
      nib2  <= nib_hi1;
      deep2 <= deep1;
      pal2  <= pal1;
    end
  end

  assign nib_sel = nib2 ? rdata[7:4] : rdata[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_index <= '0;
    end else begin
      pix_valid <= act2;
      if (!act2)      pix_index <= '0;
      else if (deep2) pix_index <= rdata;
      else            pix_index <= fbv_nibble_index(pal2, nib_sel);
    end
  end

endmodule

// File: rtl/fbv_scanout.sv
module fbv_scanout import fbv_pkg::*; #(
  parameter int DOT_DIV  = 4,
  parameter int H_TOTAL  = 416,
  parameter int V_TOTAL  = 262,
  parameter int ACTIVE_W = 320,
  parameter int ACTIVE_H = 240,
  parameter int BANK_AW  = 16,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL),
  localparam int VRAM_AW = BANK_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_we,
  input  logic [MODE_W-1:0]  mode_wdata,
  input  logic               base_we,
  input  logic [BANK_AW-1:0] base_wdata,
  input  logic [7:0]         vram_rdata,
  output logic               dot_tick,
  output logic [HW-1:0]      hcount,
  output logic [VW-1:0]      vcount,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic               vram_rd,
  output logic               pix_valid,
  output logic [7:0]         pix_index
);

  fbv_mode_t          mode_q;
  logic [BANK_AW-1:0] base_q;
  logic               unused_spare;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      base_q <= '0;
    end else begin
      if (mode_we) mode_q <= fbv_mode_t'(mode_wdata);
      if (base_we) base_q <= base_wdata;
    end
  end

  // The spare mode bit is stored with the word but steers nothing.
  assign unused_spare = mode_q.spare;

  logic          tick;
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;

  fbv_dot_div #(.DIV(DOT_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  fbv_raster #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL),
    .HW      (HW),
    .VW      (VW)
  ) u_raster (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .hc   (hc),
    .vc   (vc)
  );

  logic       nib_hi1, deep1;
  logic [1:0] pal1;

  fbv_fetch_addr #(
    .ACTIVE_W (ACTIVE_W),
    .ACTIVE_H (ACTIVE_H),
    .HW       (HW),
    .VW       (VW),
    .BANK_AW  (BANK_AW)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .hc        (hc),
    .vc        (vc),
    .disp_on   (mode_q.disp_on),
    .wide_pix  (mode_q.wide_pix),
    .pal_sel   (mode_q.pal_sel),
    .top_blank (mode_q.top_blank),
    .bot_blank (mode_q.bot_blank),
    .front_hi  (mode_q.front_hi),
    .base      (base_q),
    .addr      (vram_addr),
    .rd        (vram_rd),
    .nib_hi    (nib_hi1),
    .deep      (deep1),
    .pal       (pal1)
  );

  fbv_pixel_form u_pix (
    .clk       (clk),
    .rst       (rst),
    .rd1       (vram_rd),
    .nib_hi1   (nib_hi1),
    .deep1     (deep1),
    .pal1      (pal1),
    .rdata     (vram_rdata),
    .pix_valid (pix_valid),
    .pix_index (pix_index)
  );

  assign dot_tick = tick;
  assign hcount   = hc;
  assign vcount   = vc;

endmodule

// File: rtl/fbv_scanout_chk.sv
module fbv_scanout_chk #(
  parameter int H_TOTAL  = 416,
  parameter int V_TOTAL  = 262,
  parameter int ACTIVE_W = 320,
  parameter int HW       = 9,
  parameter int VW       = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          dot_tick,
  input logic [HW-1:0] hcount,
  input logic [VW-1:0] vcount,
  input logic          vram_rd,
  input logic          pix_valid,
  input logic [1:0]    idx_hi,
  input logic          disp_on,
  input logic          wide_pix
);

  // R1
  h_range_chk: assert property (@(posedge clk) disable iff (rst)
    hcount < HW'(H_TOTAL));

  // R1
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dot_tick && hcount != HW'(H_TOTAL - 1)) |=> hcount == $past(hcount) + 1'b1);

  // R2
  v_range_chk: assert property (@(posedge clk) disable iff (rst)
    vcount < VW'(V_TOTAL));

  // R2
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(dot_tick && hcount == HW'(H_TOTAL - 1)) |=> $stable(vcount));

  // R6
  rd_cols_chk: assert property (@(posedge clk) disable iff (rst)
    vram_rd |-> $past(hcount) < HW'(ACTIVE_W));

  // R6
  rd_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(disp_on) |-> !vram_rd);

  // R9
  nib_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !$past(wide_pix, 3)) |-> idx_hi == 2'b00);

  // R10
  valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(vram_rd, 2));

endmodule

bind fbv_scanout fbv_scanout_chk #(
  .H_TOTAL  (H_TOTAL),
  .V_TOTAL  (V_TOTAL),
  .ACTIVE_W (ACTIVE_W),
  .HW       (HW),
  .VW       (VW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dot_tick  (dot_tick),
  .hcount    (hcount),
  .vcount    (vcount),
  .vram_rd   (vram_rd),
  .pix_valid (pix_valid),
  .idx_hi    (pix_index[7:6]),
  .disp_on   (mode_q.disp_on),
  .wide_pix  (mode_q.wide_pix)
);

// File: tb/fbv_scanout_bench.sv
`timescale 1ns/1ps
module fbv_scanout_bench;

  localparam int HT = 416;
  localparam int VT = 262;
  localparam int AW = 320;
  localparam int AH = 240;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [15:0] mode_wdata = '0;
  logic        base_we = 1'b0;
  logic [15:0] base_wdata = '0;
  logic [7:0]  vram_rdata = '0;

  logic        dot_tick, vram_rd, pix_valid;
  logic [8:0]  hcount, vcount;
  logic [16:0] vram_addr;
  logic [7:0]  pix_index;

  fbv_scanout #(.DOT_DIV(1)) u_fbv_scanout (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .base_we(base_we), .base_wdata(base_wdata), .vram_rdata(vram_rdata),
    .dot_tick(dot_tick), .hcount(hcount), .vcount(vcount),
    .vram_addr(vram_addr), .vram_rd(vram_rd), .pix_valid(pix_valid),
    .pix_index(pix_index)
  );

  // Second instance with the default divider, used for the dot-enable checks.
  logic        d4_tick, d4_rd, d4_valid;
  logic [8:0]  d4_h, d4_v;
  logic [16:0] d4_addr;
  logic [7:0]  d4_idx;

  fbv_scanout u_fbv_scanout_div4 (
    .clk(clk), .rst(rst), .mode_we(1'b0), .mode_wdata(16'h0000),
    .base_we(1'b0), .base_wdata(16'h0000), .vram_rdata(8'h00),
    .dot_tick(d4_tick), .hcount(d4_h), .vcount(d4_v),
    .vram_addr(d4_addr), .vram_rd(d4_rd), .pix_valid(d4_valid),
    .pix_index(d4_idx)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Synchronous-read video memory model with address-dependent content.
  function automatic logic [7:0] ram_fn(input logic [16:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {a[16], 7'd0};
  endfunction

  always @(posedge clk) vram_rdata <= ram_fn(vram_addr);

  // Reference raster and registers (R1, R2, R11).
  int          mh = 0;
  int          mv = 0;
  logic [15:0] m_mode = '0;
  logic [15:0] m_base = '0;

  always @(posedge clk) begin
    if (rst) begin
      mh <= 0; mv <= 0; m_mode <= '0; m_base <= '0;
    end else begin
      if (mh == HT - 1) begin
        mh <= 0;
        mv <= (mv == VT - 1) ? 0 : mv + 1;
      end else begin
        mh <= mh + 1;
      end
      if (mode_we) m_mode <= mode_wdata;
      if (base_we) m_base <= base_wdata;
    end
  end

  typedef struct {
    bit v;
    int idx;
    int addr;
    bit sel;
    bit deep;
    bit spare;
  } exp_t;

  exp_t q_a[$];
  exp_t q_p[$];
  bit   mon_on = 1'b0;

  function automatic bit sample_col(input int h);
    return (h < 3) || (h >= AW - 2 && h <= AW + 1) || (h >= HT - 3) || (h % 41 == 0);
  endfunction

  function automatic exp_t predict();
    exp_t e;
    bit en, deep, fr;
    int pal, top, bot, row, col, lo, a, d;
    en   = m_mode[15];
    deep = m_mode[14];
    pal  = int'(m_mode[12:11]);
    top  = int'(m_mode[10:6]);
    bot  = int'(m_mode[5:1]);
    fr   = m_mode[0];
    e.v  = en && (mh < AW) && (mv >= top) && (mv < AH - bot);
    row  = mv - top;
    col  = deep ? mh : mh / 2;
    lo   = (int'(m_base) + row * (deep ? AW : AW / 2) + col) & 16'hFFFF;
    a    = (fr ? 65536 : 0) + lo;
    d    = int'(ram_fn(17'(a)));
    if (!e.v)      e.idx = 0;
    else if (deep) e.idx = d;
    else           e.idx = pal * 16 + ((mh % 2 == 0) ? (d >> 4) : (d & 15));
    e.addr  = a;
    e.sel   = sample_col(mh);
    e.deep  = deep;
    e.spare = m_mode[13];
    return e;
  endfunction

  // Monitor: address stage one clock behind, pixel stage three clocks behind (R10).
  always @(negedge clk) begin
    exp_t e, a, p;
    if (rst || !mon_on) begin
      q_a.delete();
      q_p.delete();
    end else begin
      e = predict();
      if (q_a.size() == 1) begin
        a = q_a.pop_front();
        if (a.sel) begin
          check(vram_rd == a.v, "R6", "vram_rd", int'(vram_rd), int'(a.v));
          if (a.v)
            check(vram_addr == 17'(a.addr), a.spare ? "R5" : "R7", "vram_addr",
                  int'(vram_addr), a.addr);
        end
      end
      if (q_p.size() == 3) begin
        p = q_p.pop_front();
        if (p.sel) begin
          // R10: pixel result lags the counter state by three clocks
          check(pix_valid == p.v, "R6", "pix_valid", int'(pix_valid), int'(p.v));
          check(pix_index == 8'(p.idx),
                !p.v ? "R10" : (p.spare ? "R5" : (p.deep ? "R8" : "R9")),
                "pix_index", int'(pix_index), p.idx);
        end
      end
      if (e.sel) begin
        check(hcount == 9'(mh), "R1", "hcount", int'(hcount), mh);
        check(vcount == 9'(mv), "R2", "vcount", int'(vcount), mv);
      end
      q_a.push_back(e);
      q_p.push_back(e);
    end
  end

  // Driver: a write during column 400 of the line before takes effect (R11).
  task automatic wr(input int line, input logic [15:0] md,
                    input bit set_base, input logic [15:0] b);
    do @(negedge clk); while (!(mh == 400 && mv == line - 1));
    mode_we    = 1'b1;
    mode_wdata = md;
    base_we    = set_base;
    base_wdata = b;
    @(negedge clk);
    mode_we = 1'b0;
    base_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R4: state held in reset
    check(hcount == 0, "R4", "hcount", int'(hcount), 0);
    check(vcount == 0, "R4", "vcount", int'(vcount), 0);
    check(pix_valid == 1'b0, "R4", "pix_valid", int'(pix_valid), 0);
    check(vram_rd == 1'b0, "R4", "vram_rd", int'(vram_rd), 0);
    check(d4_h == 0, "R4", "div4 hcount", int'(d4_h), 0);
    #1;
    rst    = 1'b0;
    mon_on = 1'b1;

    // R3: divide-by-4 enable timing after reset release
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(d4_h == 0, "R3", "hcount after 3 edges", int'(d4_h), 0);
    check(d4_tick == 1'b1, "R3", "tick after 3 edges", int'(d4_tick), 1);
    @(posedge clk);
    @(negedge clk);
    check(d4_h == 1, "R3", "hcount after 4 edges", int'(d4_h), 1);
    check(d4_tick == 1'b0, "R3", "tick after 4 edges", int'(d4_tick), 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(d4_h == 2, "R3", "hcount after 8 edges", int'(d4_h), 2);
    check(d4_valid == 1'b0, "R4", "div4 display off", int'(d4_valid), 0);

    // Line 0 runs with the reset mode (display off).
    wr(1,   16'hC000, 1'b1, 16'h0000); // 8 bpp, lower half
    wr(3,   16'h9000, 1'b0, 16'h0000); // 4 bpp, palette group 2
    wr(5,   16'hA801, 1'b1, 16'h0100); // R5: spare bit set, 4 bpp group 1, upper half
    wr(7,   16'h9A87, 1'b1, 16'hFFF0); // top 10, bottom 3, group 3, offset wraps
    wr(12,  16'hC001, 1'b1, 16'h1234); // 8 bpp, upper half
    wr(14,  16'h4001, 1'b0, 16'h0000); // display off
    wr(16,  16'hC7FE, 1'b0, 16'h0000); // 8 bpp, top 31, bottom 31
    wr(200, 16'h80FE, 1'b0, 16'h0000); // 4 bpp, top 3, bottom 31 -> last line 208
    wr(230, 16'hC000, 1'b1, 16'h0040); // 8 bpp, no letterbox -> last line 239

    do @(negedge clk); while (mv != VT - 1);
    do @(negedge clk); while (!(mv == 2 && mh == 10));
    finish_run();
  end

endmodule